// File: doc/BRIEF.md
# Dual-Mode Transmit Width Adapter

This block sits on the transmit side of a serial link, between the upper-layer word stream and the serializer. Its input is a 32-bit word, or a 40-bit word when line coding is bypassed. These words arrive on a user clock. The block re-times them into a PMA-side word on a second clock that is phase-locked to the user clock with zero ppm offset. For fast line rates the PMA clock runs at half the user clock. In that case the adapter packs two consecutive words into one 64-bit word, or one 80-bit word in bypass. For slow line rates the PMA clock runs at twice the user clock. In that case each word is cut into two 16-bit halves, or two 20-bit halves, and sent one after the other.

A 7-bit width code selects the conversion at run time. A small state machine in the PMA domain turns that code into a mode. It has four states:
- HOLD: reset, output quiet.
- WIDE: code 80.
- NARROW: code 20.
- FAULT: any other code.

The machine moves every PMA cycle, with these transitions:
- From any state to WIDE when the code is 80.
- From any state to NARROW when the code is 20.
- From any state to FAULT when the code is any other value.
- From any state to HOLD while reset is sampled high.

In FAULT the error output is raised and the data output is forced to zero. Both conversion paths keep running in FAULT, so a return to a valid code resumes the word stream without loss of pairing.

A word-phase toggle register lives in each domain. Both are cleared by the shared synchronous reset. Reset must be released so that the first clock edge sampling it low is an edge where both clocks rise together; that edge is called edge 0. The pairing of words and the order of halves count from edge 0.

Top module: `tx_width_adapter`

## Requirements
- R1: In WIDE mode (code 80) with coding enabled (`raw_mode`=0), the output word is {second word[31:0], first word[31:0]} in bits [63:0] and bits [79:64] are zero. The first word is the one sampled on the user edge that coincides with a PMA edge, so it lands in the least-significant half.
- R2: In NARROW mode (code 20) with coding enabled, each input word is sent as bits [15:0] first, then bits [31:16], in output bits [15:0], with bits [79:16] zero.
- R3: Width code 7'd80 selects WIDE and 7'd20 selects NARROW. The mode takes effect on the PMA edge that samples the code.
- R4: Any other width code makes `err` high and `dout` all zero after the PMA edge that samples it.
- R5: In WIDE mode, the pair whose first word is sampled on user edge 2j appears on `dout` after PMA edge j+4, which is a latency of 4 PMA cycles.
- R6: In NARROW mode, the word sampled on user edge k shows its first half after PMA edge 2k+2, a latency of 2 PMA cycles, and its second half after PMA edge 2k+3.
- R7: Reset is synchronous in both domains. After a PMA edge that samples reset high, `dout` is zero and `err` is low. After release, the first 4 outputs (WIDE) or the first 2 outputs (NARROW) are zero.
- R8: When the width code returns from an invalid value to the valid one, the output continues the same word stream with the same pairing and latency as if no fault had occurred.
- R9: With coding bypassed (`raw_mode`=1), WIDE outputs {second[39:0], first[39:0]} on all 80 bits. NARROW outputs bits [19:0] first, then bits [39:20], in output bits [19:0].
- R10: With coding enabled, input bits [39:32] have no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_usr | input | 1 | User-side word clock |
| clk_pma | input | 1 | PMA-side clock, half (WIDE) or double (NARROW) the user clock, phase-locked |
| rst | input | 1 | Active-high reset, sampled synchronously in both domains |
| raw_mode | input | 1 | 1 = line coding bypassed (40-bit words), 0 = 32-bit words |
| width_code | input | 7 | PMA width code: 80 = WIDE, 20 = NARROW, other = error |
| din | input | 40 | Input word on `clk_usr` |
| dout | output | 80 | PMA-side word on `clk_pma`, zero-extended |
| err | output | 1 | High while the width code is unsupported |

## Verification
The bench builds the adapter with its default parameters: a 40-bit raw word, a 32-bit coded word, a 4-stage wide pipeline, and width codes 80 and 20. With these values all four output formats can be reached: 64 and 80 bits in WIDE, 16 and 20 bits in NARROW. The bench switches the PMA clock between half and double rate around each reset. This lets the phase alignment at edge 0, the exact pair and half order, and both latencies be compared cycle by cycle against a queue of the words sent. Invalid codes are injected in the middle of each stream, so both the zeroed output and the resumption of the stream afterwards are observed. Random upper input bits are driven in coded mode to show that they do not reach the output.

// File: rtl/tx_wa_pkg.sv
`timescale 1ns/10ps
package tx_wa_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_NARROW = 2'd2,
        MODE_FAULT  = 2'd3
    } wa_mode_e;

endpackage

// File: rtl/tx_wa_mode_fsm.sv
`timescale 1ns/10ps
module tx_wa_mode_fsm
    import tx_wa_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int CODE_WIDE   = 80,
    parameter int CODE_NARROW = 20
) (
    input  logic              clk_pma,
    input  logic              rst,
    input  logic [CODE_W-1:0] width_code,
    output wa_mode_e          mode,
    output logic              fault
);

    localparam logic [CODE_W-1:0] WIDE_C   = CODE_W'(CODE_WIDE);
    localparam logic [CODE_W-1:0] NARROW_C = CODE_W'(CODE_NARROW);

    wa_mode_e state_q;
    wa_mode_e state_d;
    wa_mode_e code_mode;

    always_comb begin
        if (width_code == WIDE_C) begin
            code_mode = MODE_WIDE;
        end else if (width_code == NARROW_C) begin
            code_mode = MODE_NARROW;
        end else begin
            code_mode = MODE_FAULT;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD:   state_d = code_mode;
            MODE_WIDE:   if (code_mode != MODE_WIDE)   state_d = code_mode;
            MODE_NARROW: if (code_mode != MODE_NARROW) state_d = code_mode;
            MODE_FAULT:  if (code_mode != MODE_FAULT)  state_d = code_mode;
        endcase
    end

    // state register
    always_ff @(posedge clk_pma) begin
        if (rst) begin
            state_q <= MODE_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        mode  = state_q;
        fault = (state_q == MODE_FAULT);
    end

    AST_RESET_HOLD: assert property (@(posedge clk_pma)
        rst |=> (mode == MODE_HOLD && !fault)); // R7

    AST_WIDE_SELECT: assert property (@(posedge clk_pma) disable iff (rst)
        (width_code == WIDE_C) |=> (mode == MODE_WIDE)); // R3

    AST_NARROW_SELECT: assert property (@(posedge clk_pma) disable iff (rst)
        (width_code == NARROW_C) |=> (mode == MODE_NARROW)); // R3

    AST_BAD_CODE_FAULT: assert property (@(posedge clk_pma) disable iff (rst)
        (width_code != WIDE_C && width_code != NARROW_C) |=> fault); // R4

endmodule

// File: rtl/tx_wa_wide_pack.sv
`timescale 1ns/10ps
module tx_wa_wide_pack #(
    parameter int WORD_W = 40,
    parameter int ENC_W  = 32,
    parameter int LAT    = 4
) (
    input  logic                clk_usr,
    input  logic                clk_pma,
    input  logic                rst,
    input  logic                raw_mode,
    input  logic [WORD_W-1:0]   din,
    output logic [2*WORD_W-1:0] wide_out
);

    localparam int OUT_W = 2 * WORD_W;
    localparam int PAD_W = OUT_W - 2 * ENC_W;

    // user domain: word-phase toggle and pairing
    logic              ph_u;
    logic [WORD_W-1:0] low_q;
    logic [OUT_W-1:0]  pair_q;

    always_ff @(posedge clk_usr) begin
        if (rst) begin
            ph_u   <= 1'b0;
            low_q  <= '0;
            pair_q <= '0;
        end else begin
            ph_u <= ~ph_u;
            if (!ph_u) begin
                low_q <= din;
            end else begin
                pair_q <= {din, low_q};
            end
        end
    end

    // PMA domain: width select then fixed-length pipeline
    logic [OUT_W-1:0] fmt_pair;
    logic [OUT_W-1:0] pipe_q [LAT];

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (raw_mode) begin
                    fmt_pair = pair_q;
                end else begin
                    fmt_pair = {{PAD_W{1'b0}}, pair_q[WORD_W +: ENC_W], pair_q[0 +: ENC_W]};
                end
            end
        end else begin : g_nopad
            always_comb fmt_pair = pair_q;
        end
    endgenerate

    always_ff @(posedge clk_pma) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= fmt_pair;
            for (int i = 1; i < LAT; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign wide_out = pipe_q[LAT-1];

    AST_PHASE_ALTERNATES: assert property (@(posedge clk_usr) disable iff (rst)
        1'b1 |=> (ph_u != $past(ph_u))); // R5

    AST_FIRST_WORD_LOW: assert property (@(posedge clk_usr) disable iff (rst)
        ph_u |=> (pair_q[WORD_W-1:0] == $past(low_q))); // R1

    AST_SECOND_WORD_HIGH: assert property (@(posedge clk_usr) disable iff (rst)
        ph_u |=> (pair_q[OUT_W-1:WORD_W] == $past(din))); // R1

endmodule

// File: rtl/tx_wa_narrow_split.sv
`timescale 1ns/10ps
module tx_wa_narrow_split #(
    parameter int WORD_W = 40,
    parameter int ENC_W  = 32
) (
    input  logic                clk_usr,
    input  logic                clk_pma,
    input  logic                rst,
    input  logic                raw_mode,
    input  logic [WORD_W-1:0]   din,
    output logic [2*WORD_W-1:0] narrow_out
);

    localparam int OUT_W    = 2 * WORD_W;
    localparam int HALF_W   = WORD_W / 2;
    localparam int ENC_HALF = ENC_W / 2;
    localparam int HPAD_W   = HALF_W - ENC_HALF;

    // user domain capture
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_usr) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= din;
        end
    end

    // PMA domain: word-phase toggle, hold, half select
    logic              ph_p;
    logic [WORD_W-1:0] hold_q;
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] lo_sel;
    logic [HALF_W-1:0] hi_sel;

    always_comb begin
        if (raw_mode) begin
            lo_sel = hold_q[HALF_W-1:0];
            hi_sel = hold_q[WORD_W-1:HALF_W];
        end else begin
            lo_sel = {{HPAD_W{1'b0}}, hold_q[ENC_HALF-1:0]};
            hi_sel = {{HPAD_W{1'b0}}, hold_q[ENC_W-1:ENC_HALF]};
        end
    end

    always_ff @(posedge clk_pma) begin
        if (rst) begin
            ph_p   <= 1'b0;
            hold_q <= '0;
            half_q <= '0;
        end else begin
            ph_p <= ~ph_p;
            if (ph_p) begin
                hold_q <= word_q;
                half_q <= hi_sel;
            end else begin
                half_q <= lo_sel;
            end
        end
    end

    assign narrow_out = {{(OUT_W-HALF_W){1'b0}}, half_q};

    AST_HOLD_STEADY: assert property (@(posedge clk_pma) disable iff (rst)
        !ph_p |=> (hold_q == $past(hold_q))); // R6

    AST_UPPER_HALF_SECOND: assert property (@(posedge clk_pma) disable iff (rst)
        (ph_p && raw_mode) |=> (half_q == $past(hold_q[WORD_W-1:HALF_W]))); // R9

    AST_LOWER_HALF_FIRST: assert property (@(posedge clk_pma) disable iff (rst)
        (!ph_p && raw_mode) |=> (half_q == $past(hold_q[HALF_W-1:0]))); // R2

endmodule

// File: rtl/tx_width_adapter.sv
`timescale 1ns/10ps
module tx_width_adapter
    import tx_wa_pkg::*;
#(
    parameter int WORD_W      = 40,
    parameter int ENC_W       = 32,
    parameter int WIDE_LAT    = 4,
    parameter int CODE_W      = 7,
    parameter int CODE_WIDE   = 80,
    parameter int CODE_NARROW = 20
) (
    input  logic                clk_usr,
    input  logic                clk_pma,
    input  logic                rst,
    input  logic                raw_mode,
    input  logic [CODE_W-1:0]   width_code,
    input  logic [WORD_W-1:0]   din,
    output logic [2*WORD_W-1:0] dout,
    output logic                err
);

    localparam int OUT_W = 2 * WORD_W;

    wa_mode_e         mode;
    logic             fault;
    logic [OUT_W-1:0] wide_out;
    logic [OUT_W-1:0] narrow_out;

    tx_wa_mode_fsm #(
        .CODE_W      (CODE_W),
        .CODE_WIDE   (CODE_WIDE),
        .CODE_NARROW (CODE_NARROW)
    ) u_mode (
        .clk_pma    (clk_pma),
        .rst        (rst),
        .width_code (width_code),
        .mode       (mode),
        .fault      (fault)
    );

    tx_wa_wide_pack #(
        .WORD_W (WORD_W),
        .ENC_W  (ENC_W),
        .LAT    (WIDE_LAT)
    ) u_wide (
        .clk_usr  (clk_usr),
        .clk_pma  (clk_pma),
        .rst      (rst),
        .raw_mode (raw_mode),
        .din      (din),
        .wide_out (wide_out)
    );

    tx_wa_narrow_split #(
        .WORD_W (WORD_W),
        .ENC_W  (ENC_W)
    ) u_narrow (
        .clk_usr    (clk_usr),
        .clk_pma    (clk_pma),
        .rst        (rst),
        .raw_mode   (raw_mode),
        .din        (din),
        .narrow_out (narrow_out)
    );

    // output select by mode
    always_comb begin
        unique case (mode)
            MODE_WIDE:   dout = wide_out;
            MODE_NARROW: dout = narrow_out;
            MODE_HOLD:   dout = '0;
            MODE_FAULT:  dout = '0;
        endcase
        err = fault;
    end

    AST_FAULT_QUIET: assert property (@(posedge clk_pma) disable iff (rst)
        err |-> (dout == '0)); // R4

    AST_RESET_QUIET: assert property (@(posedge clk_pma)
        rst |=> (dout == '0 && !err)); // R7

endmodule

// File: tb/tb_tx_width_adapter.sv
`timescale 1ns/10ps
module tb_tx_width_adapter;

    logic        clk_usr = 1'b0;
    logic        clk_pma = 1'b0;
    logic        rst = 1'b1;
    logic        raw_mode = 1'b0;
    logic [6:0]  width_code = 7'd80;
    logic [39:0] din = '0;
    logic [79:0] dout;
    logic        err;

    int    tick = 0;
    bit    fast = 1'b0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    bit    is_wide = 1'b1;
    string tag = "R7";
    int    n_chk = 0;
    int    n_fail = 0;
    int    n_pma = 0;
    logic [39:0] wq[$];

    tx_width_adapter dut (
        .clk_usr    (clk_usr),
        .clk_pma    (clk_pma),
        .rst        (rst),
        .raw_mode   (raw_mode),
        .width_code (width_code),
        .din        (din),
        .dout       (dout),
        .err        (err)
    );

    // 200 MHz user clock; PMA clock at half (wide) or double (narrow), edges aligned
    always begin
        #1.25;
        tick++;
        clk_usr = (tick % 4) < 2;
        clk_pma = fast ? ((tick % 2) == 0) : ((tick % 8) < 4);
    end

    task automatic chk(input bit ok, input string t, input logic [80:0] act, input logic [80:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s n=%0d act err/dout=%h exp=%h", t, n_pma, act, exp);
        end
    endtask

    // behavioural reference, compared after every PMA edge
    always @(posedge clk_pma) begin
        logic        r_s;
        logic [6:0]  c_s;
        logic [79:0] exp;
        logic [39:0] a, b;
        logic [19:0] h;
        int j, m;
        r_s = rst;
        c_s = width_code;
        #0.5;
        if (chk_on) begin
            if (r_s) begin
                chk(dout == '0 && err == 1'b0, "R7 reset", {err, dout}, 81'h0);
                n_pma = 0;
            end else if (c_s != 7'd80 && c_s != 7'd20) begin
                chk(dout == '0 && err == 1'b1, "R4 bad code", {err, dout}, {1'b1, 80'h0});
                n_pma++;
            end else begin
                exp = '0;
                if (is_wide && n_pma >= 4) begin
                    j = n_pma - 4;
                    a = (2*j < wq.size()) ? wq[2*j] : '0;
                    b = (2*j+1 < wq.size()) ? wq[2*j+1] : '0;
                    exp = raw_mode ? {b, a} : {16'h0, b[31:0], a[31:0]};
                end else if (!is_wide && n_pma >= 2) begin
                    m = n_pma - 2;
                    a = (m/2 < wq.size()) ? wq[m/2] : '0;
                    if (m % 2 == 0) h = raw_mode ? a[19:0]  : {4'h0, a[15:0]};
                    else            h = raw_mode ? a[39:20] : {4'h0, a[31:16]};
                    exp = {60'h0, h};
                end
                chk(dout == exp && err == 1'b0,
                    (is_wide ? (n_pma < 4) : (n_pma < 2)) ? "R7 startup zero" : tag,
                    {err, dout}, {1'b0, exp});
                n_pma++;
            end
        end
    end

    task automatic push_word();
        logic [63:0] r64;
        r64 = {$urandom(), $urandom()};
        din = r64[39:0];
        wq.push_back(r64[39:0]);
    endtask

    task automatic run_phase(input bit wide_m, input bit raw, input int cycles,
                             input logic [6:0] bad1, input logic [6:0] bad2, input string t);
        @(posedge clk_usr);
        #1;
        rst = 1'b1;
        repeat (3) @(posedge clk_usr);
        #1;
        fast = !wide_m;
        is_wide = wide_m;
        raw_mode = raw;
        width_code = wide_m ? 7'd80 : 7'd20;
        tag = t;
        wq.delete();
        repeat (4) @(posedge clk_usr);
        do @(tick); while (tick % 8 != 7);
        #0.3;
        rst = 1'b0;
        push_word();
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk_usr);
            #1;
            push_word();
            if (i == 20) width_code = bad1;
            if (i == 22) width_code = bad2;
            if (i == 24) begin
                width_code = wide_m ? 7'd80 : 7'd20;
                tag = {t, " R8 resume"};
            end
        end
    endtask

    initial begin
        repeat (6) @(posedge clk_usr);
        chk_on = 1'b1;
        run_phase(1'b1, 1'b0, 60, 7'd55, 7'd0,   "R1 R3 R5 R10 wide coded");
        run_phase(1'b0, 1'b0, 60, 7'd0,  7'd127, "R2 R3 R6 R10 narrow coded");
        run_phase(1'b1, 1'b1, 60, 7'd81, 7'd40,  "R9 R5 wide raw");
        run_phase(1'b0, 1'b1, 60, 7'd21, 7'd19,  "R9 R6 narrow raw");
        @(posedge clk_usr);
        #1;
        rst = 1'b1;
        repeat (4) @(posedge clk_usr);
        chk_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule